// File: doc/BRIEF.md
# Shared-Counter Multi-Channel PWM Timer

This block produces several edge-aligned PWM waveforms from a single prescaled up-counter. All channels share the count and one 16-bit modulo that sets the period. Each channel has its own compare value, which sets the duty, and its own polarity. Software programs the block through a small register bus with a one-cycle write strobe and a combinational read path. A parameter register reports how many channels are built.

To start a waveform, software stops the counter and loads the modulo and the channel compare values, which take effect at once while the counter is stopped. It then enables each channel by setting its edge-PWM select bit and a polarity code, and starts the counter. While the counter runs, new modulo and compare values are held back until the next counter wrap, so a period is never cut short or glitched. Each channel also has a sticky match flag that software clears by writing 1 to it.

Top module: `pwm_shared_timer`

## Requirements
- R1: After reset, offset 0x04 reads the channel count (NUM_CH, 4 by default) in bits [7:0]. The control register, the counter and every channel register read 0, the modulo reads 0xFFFF, and all PWM outputs and flags are 0.
- R2: The counter advances only when control bits [4:3] equal 01. It then advances once every 2^PS clocks, where PS is control bits [2:0]. With any other mode value the count holds.
- R3: The counter counts from 0 up to the active modulo value. On the next prescaled tick it returns to 0, so a period lasts modulo+1 ticks. If the count is already above the modulo, that tick also returns it to 0.
- R4: A write to control changes bits [2:0] only while the counter is stopped. A write made while it runs leaves PS unchanged. Bit 5, the centre-aligned select, always reads 0.
- R5: A write to the modulo register (offset 0x18) takes effect at once while the counter is stopped. While it runs, the new value becomes active at the next wrap. A read returns the value last written.
- R6: In a channel control register, bit 5 selects edge PWM and bits [3:2] select polarity. Code 10 drives the output high while count < compare and low otherwise. Code 01 drives the inverse.
- R7: A channel whose bit 5 is 0, or whose polarity code is 00 or 11, drives its output low. Bit 4 is stored and read back but does not alter the waveform.
- R8: A compare value of 0 gives 0% duty. A compare value above the active modulo gives 100% duty (constant high for code 10).
- R9: A write to a channel value register (offset 0x24+8n) takes effect at once while the counter is stopped. While it runs, it takes effect at the next wrap. A read returns the value last written.
- R10: A channel flag (control bit 7) sets on a prescaled tick at which the count equals that channel's active compare value. Writing 1 to bit 7 clears it, writing 0 leaves it, and a set in the same cycle wins over the clear.
- R11: The control register is at 0x10, the counter at 0x14, and channel n control at 0x20+8n. The counter register is read-only: writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational on bus_addr |
| pwm_out | output | NUM_CH | PWM waveform per channel |
| ch_flag | output | NUM_CH | Sticky compare-match flag per channel |

## Verification
A wrong count or prescaler phase shows on every enabled channel's pwm_out. The edge moves within one tick, and the error compounds at each wrap. A wrong active compare or modulo, such as a value taken early instead of at the wrap, moves an edge inside the current period. The flag outputs expose a match decided on the wrong tick in the next cycle. Because the outputs are compared on every clock against a behavioural model, an internal error appears at the ports within one prescaled period of its cause.

// File: rtl/pwmt_pkg.sv
// Package: register offsets and field positions shared by the timer modules.
// Assumes byte-addressed registers spaced four bytes apart.
package pwmt_pkg;
    localparam logic [7:0] OFS_INFO   = 8'h04;
    localparam logic [7:0] OFS_CTRL   = 8'h10;
    localparam logic [7:0] OFS_COUNT  = 8'h14;
    localparam logic [7:0] OFS_MODULO = 8'h18;
    localparam logic [7:0] OFS_CH_CTL = 8'h20;
    localparam logic [7:0] OFS_CH_VAL = 8'h24;
    localparam int         CH_STRIDE  = 8;

    localparam logic [1:0] MODE_RUN   = 2'b01;
    localparam logic [1:0] POL_NORMAL = 2'b10;
    localparam logic [1:0] POL_INVERT = 2'b01;

    // Offset of the control register of channel idx.
    function automatic logic [7:0] ch_ctl_ofs(input int idx);
        return OFS_CH_CTL + 8'(idx * CH_STRIDE);
    endfunction

    // Offset of the value register of channel idx.
    function automatic logic [7:0] ch_val_ofs(input int idx);
        return OFS_CH_VAL + 8'(idx * CH_STRIDE);
    endfunction
endpackage

// File: rtl/pwmt_prescaler.sv
// Prescaler: issues a one-cycle tick every 2^ps clocks while run is high.
// Assumes ps changes only while run is low; the divider restarts from 0
// whenever run is low.
module pwmt_prescaler #(
    parameter int PS_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic [PS_W-1:0] ps,
    output logic            tick
);
    localparam int DIV_W = (1 << PS_W) - 1;

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] mask;

    // Build a mask of the low ps bits of the divider.
    always_comb begin
        for (int b = 0; b < DIV_W; b++) begin
            mask[b] = (b < int'(ps));
        end
    end

    assign tick = run && ((div_q & mask) == mask);

    // Free-running divider, cleared while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) div_q <= '0;
        else                div_q <= div_q + 1'b1;
    end
endmodule

// File: rtl/pwmt_counter.sv
// Shared counter with an active and a pending modulo register.
// Assumes tick only pulses while run is high. Counts 0..mod_act and returns
// to 0; modulo writes are immediate when stopped, deferred to wrap otherwise.
module pwmt_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic             mod_wr,
    input  logic [CNT_W-1:0] mod_wdata,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] mod_pend,
    output logic             wrap
);
    logic [CNT_W-1:0] mod_act;

    assign wrap = tick && (cnt >= mod_act);

    // Advance or return the count on each prescaled tick.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (wrap) cnt <= '0;
        else if (tick) cnt <= cnt + 1'b1;
    end

    // Hold the written modulo and move it into use at the right time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mod_act  <= '1;
            mod_pend <= '1;
        end else if (mod_wr && !run) begin
            mod_act  <= mod_wdata;
            mod_pend <= mod_wdata;
        end else begin
            if (mod_wr) mod_pend <= mod_wdata;
            if (wrap)   mod_act  <= mod_pend;
        end
    end

    // R3
    wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt >= mod_act) |=> (cnt == '0));
    // R2
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(cnt));
    // R5
    mod_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !wrap) |=> $stable(mod_act));
endmodule

// File: rtl/pwmt_channel.sv
// One PWM channel: compare value (pending and active), mode and polarity bits,
// a sticky match flag, and the waveform decode.
// Assumes cnt, tick and wrap come from the shared counter.
module pwmt_channel #(
    parameter int CNT_W  = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              tick,
    input  logic              wrap,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              ctl_wr,
    input  logic              val_wr,
    input  logic [7:0]        ctl_wdata,
    input  logic [CNT_W-1:0]  val_wdata,
    output logic [DATA_W-1:0] ctl_rd,
    output logic [DATA_W-1:0] val_rd,
    output logic              pwm,
    output logic              flag
);
    import pwmt_pkg::*;

    logic [CNT_W-1:0] cv_pend, cv_act;
    logic             edge_sel, aux_sel;
    logic [1:0]       pol;
    logic             enabled, below, hit;
    logic             unused_ctl_bits;

    assign unused_ctl_bits = ^{ctl_wdata[6], ctl_wdata[1:0]};

    // Mode and polarity bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            edge_sel <= 1'b0;
            aux_sel  <= 1'b0;
            pol      <= 2'b00;
        end else if (ctl_wr) begin
            edge_sel <= ctl_wdata[5];
            aux_sel  <= ctl_wdata[4];
            pol      <= ctl_wdata[3:2];
        end
    end

    // Compare value, immediate while stopped, else loaded at wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cv_pend <= '0;
            cv_act  <= '0;
        end else if (val_wr && !run) begin
            cv_pend <= val_wdata;
            cv_act  <= val_wdata;
        end else begin
            if (val_wr) cv_pend <= val_wdata;
            if (wrap)   cv_act  <= cv_pend;
        end
    end

    assign hit = tick && (cnt == cv_act);

    // Sticky match flag; a new match wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) flag <= 1'b0;
        else        flag <= hit || (flag && !(ctl_wr && ctl_wdata[7]));
    end

    assign enabled = edge_sel && (pol == POL_NORMAL || pol == POL_INVERT);
    assign below   = cnt < cv_act;
    assign pwm     = enabled && (pol[1] ? below : !below);

    assign ctl_rd = DATA_W'({flag, 1'b0, edge_sel, aux_sel, pol, 2'b00});
    assign val_rd = DATA_W'(cv_pend);

    // R9
    cv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !wrap) |=> $stable(cv_act));
    // R10
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> flag);
    // R7
    off_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !edge_sel |-> !pwm);
endmodule

// File: rtl/pwm_shared_timer.sv
// Top: register decode, control register and the per-channel array around a
// shared prescaler and counter. Assumes a single-cycle write strobe
// (bus_sel & bus_wr) and a combinational read on bus_addr.
module pwm_shared_timer #(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16,
    parameter int PS_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NUM_CH-1:0] pwm_out,
    output logic [NUM_CH-1:0] ch_flag
);
    import pwmt_pkg::*;

    localparam int MODE_LSB = PS_W;

    logic                          wr_en, run, tick, wrap;
    logic [1:0]                    mode_q;
    logic [PS_W-1:0]               ps_q;
    logic [CNT_W-1:0]              cnt, mod_pend;
    logic [NUM_CH-1:0][DATA_W-1:0] ctl_rd, val_rd;
    logic                          unused_wdata_hi;

    assign unused_wdata_hi = ^bus_wdata[DATA_W-1:CNT_W];
    assign wr_en = bus_sel && bus_wr;
    assign run   = (mode_q == MODE_RUN);

    // Control register: mode always writable, prescaler only while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= 2'b00;
            ps_q   <= '0;
        end else if (wr_en && bus_addr == ADDR_W'(OFS_CTRL)) begin
            mode_q <= bus_wdata[MODE_LSB +: 2];
            if (!run) ps_q <= bus_wdata[PS_W-1:0];
        end
    end

    pwmt_prescaler #(.PS_W(PS_W)) u_presc (
        .clk(clk), .rst_n(rst_n), .run(run), .ps(ps_q), .tick(tick)
    );

    pwmt_counter #(.CNT_W(CNT_W)) u_count (
        .clk(clk), .rst_n(rst_n), .run(run), .tick(tick),
        .mod_wr(wr_en && bus_addr == ADDR_W'(OFS_MODULO)),
        .mod_wdata(bus_wdata[CNT_W-1:0]),
        .cnt(cnt), .mod_pend(mod_pend), .wrap(wrap)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        pwmt_channel #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_ch (
            .clk(clk), .rst_n(rst_n), .run(run), .tick(tick), .wrap(wrap),
            .cnt(cnt),
            .ctl_wr(wr_en && bus_addr == ADDR_W'(ch_ctl_ofs(g))),
            .val_wr(wr_en && bus_addr == ADDR_W'(ch_val_ofs(g))),
            .ctl_wdata(bus_wdata[7:0]),
            .val_wdata(bus_wdata[CNT_W-1:0]),
            .ctl_rd(ctl_rd[g]), .val_rd(val_rd[g]),
            .pwm(pwm_out[g]), .flag(ch_flag[g])
        );
    end

    // Read multiplexer.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(OFS_INFO))   bus_rdata = DATA_W'(NUM_CH);
        if (bus_addr == ADDR_W'(OFS_CTRL))   bus_rdata = DATA_W'({mode_q, ps_q});
        if (bus_addr == ADDR_W'(OFS_COUNT))  bus_rdata = DATA_W'(cnt);
        if (bus_addr == ADDR_W'(OFS_MODULO)) bus_rdata = DATA_W'(mod_pend);
        for (int i = 0; i < NUM_CH; i++) begin
            if (bus_addr == ADDR_W'(ch_ctl_ofs(i))) bus_rdata = ctl_rd[i];
            if (bus_addr == ADDR_W'(ch_val_ofs(i))) bus_rdata = val_rd[i];
        end
    end

    // R4
    ps_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> $stable(ps_q));
    // R2
    stop_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !tick);
endmodule

// File: tb/test_pwm_shared_timer.sv
module test_pwm_shared_timer;
    localparam int N = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bsel = 1'b0, bwr = 1'b0;
    logic [7:0]  baddr = 8'h00;
    logic [31:0] bwdata = 32'h0;
    logic [31:0] brdata;
    logic [N-1:0] pwm_out, ch_flag;

    int total = 0, bad = 0;
    bit finished = 0;

    // behavioural model state
    int m_mode, m_ps, m_pre, m_cnt, m_mod, m_modp;
    int m_cvp[N], m_cva[N], m_msb[N], m_msa[N], m_els[N], m_flag[N];

    always #5 clk = ~clk;

    pwm_shared_timer i_pwm_shared_timer (
        .clk(clk), .rst_n(rst_n), .bus_sel(bsel), .bus_wr(bwr),
        .bus_addr(baddr), .bus_wdata(bwdata), .bus_rdata(brdata),
        .pwm_out(pwm_out), .ch_flag(ch_flag)
    );

    function automatic int ctl_a(int i); return 8'h20 + 8 * i; endfunction
    function automatic int val_a(int i); return 8'h24 + 8 * i; endfunction

    // Model update, one step per clock.
    always @(posedge clk) begin
        bit run, tick, wrap, wen;
        int msk;
        if (!rst_n) begin
            m_mode = 0; m_ps = 0; m_pre = 0; m_cnt = 0;
            m_mod = 65535; m_modp = 65535;
            for (int i = 0; i < N; i++) begin
                m_cvp[i] = 0; m_cva[i] = 0; m_msb[i] = 0;
                m_msa[i] = 0; m_els[i] = 0; m_flag[i] = 0;
            end
        end else begin
            run  = (m_mode == 1);
            msk  = (1 << m_ps) - 1;
            tick = run && ((m_pre & msk) == msk);
            wrap = tick && (m_cnt >= m_mod);
            wen  = bsel && bwr;
            for (int i = 0; i < N; i++) begin
                m_flag[i] = (tick && m_cnt == m_cva[i]) ||
                            (m_flag[i] != 0 && !(wen && baddr == ctl_a(i) && bwdata[7]));
                if (wen && baddr == val_a(i) && !run) m_cva[i] = bwdata[15:0];
                else if (wrap) m_cva[i] = m_cvp[i];
                if (wen && baddr == val_a(i)) m_cvp[i] = bwdata[15:0];
                if (wen && baddr == ctl_a(i)) begin
                    m_msb[i] = bwdata[5]; m_msa[i] = bwdata[4]; m_els[i] = bwdata[3:2];
                end
            end
            if (wen && baddr == 8'h18 && !run) m_mod = bwdata[15:0];
            else if (wrap) m_mod = m_modp;
            if (wen && baddr == 8'h18) m_modp = bwdata[15:0];
            if (tick) m_cnt = wrap ? 0 : m_cnt + 1;
            m_pre = run ? ((m_pre + 1) & 127) : 0;
            if (wen && baddr == 8'h10) begin
                m_mode = bwdata[4:3];
                if (!run) m_ps = bwdata[2:0];
            end
        end
    end

    function automatic logic [N-1:0] exp_pwm();
        logic [N-1:0] r;
        for (int i = 0; i < N; i++) begin
            bit en, lo;
            en = m_msb[i] != 0 && (m_els[i] == 2 || m_els[i] == 1);
            lo = m_cnt < m_cva[i];
            r[i] = en && (m_els[i] == 2 ? lo : !lo);
        end
        return r;
    endfunction

    function automatic logic [N-1:0] exp_flag();
        logic [N-1:0] r;
        for (int i = 0; i < N; i++) r[i] = m_flag[i] != 0;
        return r;
    endfunction

    // Compare the outputs with the model on every clock.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            total++;
            if (pwm_out !== exp_pwm()) begin
                bad++;
                $display("FAIL R6/R7/R8/R9 pwm_out act=%b exp=%b t=%0t", pwm_out, exp_pwm(), $time);
            end
            total++;
            if (ch_flag !== exp_flag()) begin
                bad++;
                $display("FAIL R10 ch_flag act=%b exp=%b t=%0t", ch_flag, exp_flag(), $time);
            end
        end
    end

    task automatic wr(input int a, input int d);
        @(negedge clk);
        bsel = 1; bwr = 1; baddr = 8'(a); bwdata = 32'(d);
        @(negedge clk);
        bsel = 0; bwr = 0;
    endtask

    task automatic rd_chk(input int a, input int expv, input string tag);
        logic [31:0] v;
        @(negedge clk);
        bsel = 1; bwr = 0; baddr = 8'(a);
        #1 v = brdata;
        bsel = 0;
        total++;
        if (v !== 32'(expv)) begin
            bad++;
            $display("FAIL %s addr=%h act=%h exp=%h", tag, a, v, expv);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int c0;
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset values
        rd_chk(8'h04, 4, "R1 channel count");
        rd_chk(8'h10, 0, "R1 ctrl reset");
        rd_chk(8'h14, 0, "R1 count reset");
        rd_chk(8'h18, 32'hFFFF, "R1 modulo reset");
        rd_chk(8'h20, 0, "R1 ch0 ctl reset");
        rd_chk(8'h3C, 0, "R1 ch3 val reset");
        total++;
        if (pwm_out !== 0 || ch_flag !== 0) begin
            bad++; $display("FAIL R1 outputs act=%b/%b exp=0", pwm_out, ch_flag);
        end
        // R5 immediate modulo while stopped; R9 immediate compare while stopped
        wr(8'h18, 9);
        rd_chk(8'h18, 9, "R5 modulo readback");
        wr(val_a(0), 4); wr(ctl_a(0), 32'h28);   // normal
        wr(val_a(1), 7); wr(ctl_a(1), 32'h24);   // inverted
        wr(val_a(2), 0); wr(ctl_a(2), 32'h28);   // R8 0%
        wr(val_a(3), 20); wr(ctl_a(3), 32'h28);  // R8 100%
        rd_chk(val_a(1), 7, "R9 value readback");
        rd_chk(ctl_a(1), 32'h24, "R11 ch1 ctl offset");
        // R2 run at divide 1
        wr(8'h10, 32'h08);
        idle(40);
        // R4 prescaler locked and centre bit reads 0
        wr(8'h10, 32'h2B);
        rd_chk(8'h10, 32'h08, "R4 ps locked while running");
        // R10 flag observed then cleared
        idle(12);
        rd_chk(ctl_a(0), 32'hA8, "R10 flag set");
        wr(ctl_a(0), 32'hA8);
        idle(3);
        // R5 and R9 deferred while running
        wr(8'h18, 5);
        rd_chk(8'h18, 5, "R5 modulo pending readback");
        wr(val_a(0), 2);
        idle(40);
        // R2 stop holds the count
        wr(8'h10, 0);
        @(negedge clk); baddr = 8'h14; #1 c0 = brdata;
        idle(6);
        rd_chk(8'h14, c0, "R2 count holds when stopped");
        // R11 counter write ignored
        wr(8'h14, 3);
        rd_chk(8'h14, c0, "R11 count read-only");
        // R2 divide by 4
        wr(8'h10, 32'h0A);
        rd_chk(8'h10, 32'h0A, "R4 ps accepted while stopped");
        idle(70);
        // R7 disabled and reserved polarity
        wr(ctl_a(1), 0);
        wr(ctl_a(0), 32'h2C);
        wr(ctl_a(2), 32'h18);
        idle(30);
        total++;
        if (pwm_out[1:0] !== 2'b00) begin
            bad++; $display("FAIL R7 disabled outputs act=%b exp=00", pwm_out[1:0]);
        end
        // R3 modulo below count while stopped, then run: count returns to 0
        wr(8'h10, 0);
        wr(8'h18, 1);
        wr(8'h10, 32'h08);
        idle(20);
        @(negedge clk); baddr = 8'h14; #1 v = brdata;
        total++;
        if (v > 1) begin
            bad++; $display("FAIL R3 count above modulo act=%0d exp<=1", v);
        end
        idle(4);
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule